// File: doc/BRIEF.md
# Gate Driver Protection Controller

This block is the digital core of one channel of an isolated gate driver for a power switch. It turns a pair of command inputs (one true, one inverted) and an active-low enable into a single gate-on command. Around that command it enforces the protections of the channel. It suppresses short glitches on the command and enable pins. It watches a desaturation comparator once the switch has had time to saturate, and latches a fault when the comparator trips. It blocks the gate while either supply is in undervoltage. It drops the gate and reports an internal error when the link-alive pulses from the isolation channel stop arriving.

The active-low enable has a second role: it clears a latched fault. The clear happens only when the enable returns high after a low phase that lasted at least the minimum reset time. The ready output reports that both supplies are good and the link is alive, and it needs no reset. The output-side undervoltage status reaches the ready output only after a short fixed delay. All asynchronous pins pass through two-flop synchronizers first. Every time constant is a parameter counted in clock cycles.

Top module: `gdp_ctrl`

## Requirements
- R1: With no error present, `gate_on_o` is 1 when `cmd_pos_i`=1, `cmd_neg_i`=0 and `en_clr_n_i`=1. Every other combination of these three inputs gives 0, within 2+GLITCH+1 cycles.
- R2: A pulse shorter than GLITCH cycles on `cmd_pos_i`, `cmd_neg_i` or `en_clr_n_i` has no effect on `gate_on_o`. A pulse of GLITCH cycles or more passes.
- R3: While `gate_on_o`=0, a high `desat_i` is ignored. It is also ignored during the first BLANK cycles after the gate turns on. In both cases `fault_n_o` stays 1.
- R4: If `desat_i` stays high for DFILT consecutive synchronized cycles after blanking, `gate_on_o` goes to 0 and `fault_n_o` goes to 0. Both hold whatever the commands do, until the fault is cleared.
- R5: A `desat_i` pulse shorter than DFILT cycles after blanking leaves `fault_n_o`=1 and the gate on.
- R6: A latched fault clears on the rising edge of `en_clr_n_i`, but only if that input was low for at least RST_MIN cycles. A shorter low phase leaves `fault_n_o`=0.
- R7: While `uv_in_i`=1 or `uv_out_i`=1, `gate_on_o` is 0 and the commands are ignored. `ready_o` is 0 as well.
- R8: `uv_in_i` reaches `ready_o` after the synchronizer only. `uv_out_i` reaches it UV_DLY cycles later, so `ready_o` is still 1 four cycles after `uv_out_i` rises, while `gate_on_o` is already 0.
- R9: If no rising edge arrives on `link_alive_i` for WDOG cycles, `ready_o` and `gate_on_o` go to 0. Both recover after the next rising edge.
- R10: After `rst_n`, `gate_on_o`=0 and `fault_n_o`=1. With the link alive and both supplies good, `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| cmd_pos_i | input | 1 | Non-inverting gate command |
| cmd_neg_i | input | 1 | Inverting gate command |
| en_clr_n_i | input | 1 | Active-low shutdown; a long low phase clears the fault on release |
| desat_i | input | 1 | Desaturation comparator flag |
| uv_in_i | input | 1 | Input-side undervoltage flag |
| uv_out_i | input | 1 | Output-side undervoltage flag |
| link_alive_i | input | 1 | Alive pulses from the isolation channel |
| gate_on_o | output | 1 | Gate-on command to the output stage |
| fault_n_o | output | 1 | Active-low desaturation fault flag |
| ready_o | output | 1 | Supplies good and link healthy |

## Verification
The assertions assume that the pins are synchronized before any filter sees them. They also assume that pulses on `link_alive_i` arrive often enough for the watchdog to remain satisfied except when stopping them is the point of a test. The bench drives every input at the falling clock edge. It stops the alive generator only inside the watchdog scenario. It lowers `desat_i` before it clears a fault, so that the clear and a fresh trip never compete in the same cycle except where that ordering is intended.

// File: rtl/gdp_pkg.sv
package gdp_pkg;
  typedef struct packed {
    logic cmd_pos;
    logic cmd_neg;
    logic en_clr_n;
    logic desat;
    logic uv_in;
    logic uv_out;
    logic alive;
  } gdp_pins_t;

  localparam int unsigned PIN_W = $bits(gdp_pins_t);
  localparam gdp_pins_t PIN_RST = '{cmd_pos: 1'b0, cmd_neg: 1'b1, en_clr_n: 1'b0,
                                   desat: 1'b0, uv_in: 1'b1, uv_out: 1'b1, alive: 1'b0};
endpackage

// File: rtl/gdp_sync.sv
module gdp_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= INIT;
      q  <= INIT;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gdp_glitch.sv
module gdp_glitch #(
  parameter int unsigned N = 4,
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned CW = $clog2(N) + 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= INIT;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt == CW'(N - 1)) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r2_change_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> $past(d) == q);
endmodule

// File: rtl/gdp_desat.sv
module gdp_desat #(
  parameter int unsigned BLANK = 40,
  parameter int unsigned DFILT = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic desat_i,
  output logic trip_o
);
  localparam int unsigned BW = $clog2(BLANK + 1);
  localparam int unsigned FW = $clog2(DFILT + 1);
  logic [BW-1:0] bcnt;
  logic [FW-1:0] fcnt;
  logic blank_done, armed;

  assign blank_done = (bcnt == BW'(BLANK));
  assign armed      = gate_i && blank_done && desat_i;
  assign trip_o     = armed && (fcnt == FW'(DFILT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      fcnt <= '0;
    end else begin
      if (!gate_i) bcnt <= '0;
      else if (!blank_done) bcnt <= bcnt + 1'b1;
      if (!armed) fcnt <= '0;
      else if (fcnt != FW'(DFILT - 1)) fcnt <= fcnt + 1'b1;
    end
  end

  a_r3_trip_only_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> gate_i && $past(gate_i));
endmodule

// File: rtl/gdp_fault.sv
module gdp_fault #(
  parameter int unsigned RST_MIN = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s_i,
  input  logic trip_i,
  output logic fault_o
);
  localparam int unsigned LW = $clog2(RST_MIN + 1);
  logic [LW-1:0] lowcnt;
  logic en_prev, clr;

  assign clr = en_s_i && !en_prev && (lowcnt == LW'(RST_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt  <= '0;
      en_prev <= 1'b1;
      fault_o <= 1'b0;
    end else begin
      en_prev <= en_s_i;
      if (en_s_i) lowcnt <= '0;
      else if (lowcnt != LW'(RST_MIN)) lowcnt <= lowcnt + 1'b1;
      if (trip_i) fault_o <= 1'b1;
      else if (clr) fault_o <= 1'b0;
    end
  end

  a_r4_trip_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> fault_o);
  a_r6_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o) |-> $past(en_s_i) && !$past(en_prev));
endmodule

// File: rtl/gdp_ctrl.sv
module gdp_ctrl
  import gdp_pkg::*;
#(
  parameter int unsigned GLITCH  = 4,
  parameter int unsigned BLANK   = 40,
  parameter int unsigned DFILT   = 25,
  parameter int unsigned RST_MIN = 80,
  parameter int unsigned WDOG    = 200,
  parameter int unsigned UV_DLY  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_pos_i,
  input  logic cmd_neg_i,
  input  logic en_clr_n_i,
  input  logic desat_i,
  input  logic uv_in_i,
  input  logic uv_out_i,
  input  logic link_alive_i,
  output logic gate_on_o,
  output logic fault_n_o,
  output logic ready_o
);
  localparam int unsigned WW = $clog2(WDOG + 1);

  gdp_pins_t pins, pins_s;
  assign pins = '{cmd_pos: cmd_pos_i, cmd_neg: cmd_neg_i, en_clr_n: en_clr_n_i,
                  desat: desat_i, uv_in: uv_in_i, uv_out: uv_out_i, alive: link_alive_i};

  gdp_sync #(.W(PIN_W), .INIT(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s));

  logic [2:0] raw3, filt3;
  localparam logic [2:0] FINIT = {PIN_RST.cmd_pos, PIN_RST.cmd_neg, PIN_RST.en_clr_n};
  assign raw3 = {pins_s.cmd_pos, pins_s.cmd_neg, pins_s.en_clr_n};

  for (genvar i = 0; i < 3; i++) begin : g_flt
    gdp_glitch #(.N(GLITCH), .INIT(FINIT[i])) u_glitch (
      .clk(clk), .rst_n(rst_n), .d(raw3[i]), .q(filt3[i]));
  end

  logic cmd_f, gate_q, trip, fault_q, uv_any, link_ok, alive_prev, ready_q;
  logic [WW-1:0] wcnt;
  logic [UV_DLY-1:0] uvsh;

  assign cmd_f   = filt3[2] && !filt3[1] && filt3[0];
  assign uv_any  = pins_s.uv_in || pins_s.uv_out;
  assign link_ok = (wcnt != WW'(WDOG));

  gdp_desat #(.BLANK(BLANK), .DFILT(DFILT)) u_desat (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_q), .desat_i(pins_s.desat), .trip_o(trip));

  gdp_fault #(.RST_MIN(RST_MIN)) u_fault (
    .clk(clk), .rst_n(rst_n), .en_s_i(pins_s.en_clr_n), .trip_i(trip), .fault_o(fault_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt       <= '0;
      alive_prev <= 1'b0;
      uvsh       <= '1;
      gate_q     <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      alive_prev <= pins_s.alive;
      if (pins_s.alive && !alive_prev) wcnt <= '0;
      else if (link_ok) wcnt <= wcnt + 1'b1;
      uvsh    <= {uvsh[UV_DLY-2:0], pins_s.uv_out};
      gate_q  <= cmd_f && !uv_any && link_ok && !fault_q && !trip;
      ready_q <= !pins_s.uv_in && !uvsh[UV_DLY-1] && link_ok;
    end
  end

  assign gate_on_o = gate_q;
  assign fault_n_o = !fault_q;
  assign ready_o   = ready_q;

  a_r4_fault_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> !gate_q);
  a_r7_uv_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
    uv_any |=> !gate_q);
  a_r9_link_loss_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> !gate_q && !ready_q);
  a_r1_gate_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> $past(filt3[0]));
endmodule

// File: tb/gdp_ctrl_test.sv
module gdp_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cmd_pos = 0, cmd_neg = 1, en = 0, desat = 0, uv_in = 1, uv_out = 1, alive = 0;
  logic alive_run = 1;
  logic gate, fault_n, ready;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  gdp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_pos_i(cmd_pos), .cmd_neg_i(cmd_neg),
    .en_clr_n_i(en), .desat_i(desat), .uv_in_i(uv_in), .uv_out_i(uv_out),
    .link_alive_i(alive), .gate_on_o(gate), .fault_n_o(fault_n), .ready_o(ready));

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      alive = alive_run && (k % 50 == 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic watch(input int n, output logic any_hi, output logic any_lo);
    any_hi = 0; any_lo = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate) any_hi = 1; else any_lo = 1;
    end
  endtask

  task automatic t_reset;
    cyc(5);
    chk("R10 gate after reset", gate, 0);
    chk("R10 fault_n after reset", fault_n, 1);
    uv_in = 0; uv_out = 0;
    cyc(20);
    chk("R10 ready with supplies good", ready, 1);
  endtask

  task automatic t_modes;
    en = 1; cmd_pos = 1; cmd_neg = 0; cyc(12);
    chk("R1 pos=1 neg=0 en=1", gate, 1);
    cmd_neg = 1; cyc(12);
    chk("R1 neg high", gate, 0);
    cmd_pos = 0; cmd_neg = 0; cyc(12);
    chk("R1 pos low", gate, 0);
    cmd_pos = 1; en = 0; cyc(12);
    chk("R1 enable low", gate, 0);
    en = 1; cyc(12);
    chk("R1 re-enabled", gate, 1);
    cmd_pos = 0; cyc(12);
  endtask

  task automatic t_glitch;
    logic hi, lo;
    cmd_pos = 1; cyc(3); cmd_pos = 0;
    watch(20, hi, lo);
    chk("R2 short pos pulse suppressed", hi, 0);
    cmd_pos = 1; cyc(6); cmd_pos = 0;
    watch(20, hi, lo);
    chk("R2 long pos pulse passes", hi, 1);
    cmd_pos = 1; cyc(12);
    en = 0; cyc(3); en = 1;
    watch(20, hi, lo);
    chk("R2 short enable low ignored", lo, 0);
    cmd_neg = 1; cyc(2); cmd_neg = 0;
    watch(20, hi, lo);
    chk("R2 short neg pulse ignored", lo, 0);
  endtask

  task automatic t_desat;
    logic hi, lo;
    cmd_pos = 0; cyc(12);
    desat = 1; cyc(60); desat = 0;
    chk("R3 desat while off ignored", fault_n, 1);
    cmd_pos = 1; cyc(6); desat = 1; cyc(25); desat = 0; cyc(40);
    chk("R3 desat in blanking ignored", fault_n, 1);
    chk("R3 gate still on", gate, 1);
    desat = 1; cyc(10); desat = 0; cyc(30);
    chk("R5 short desat pulse fault_n", fault_n, 1);
    chk("R5 short desat pulse gate", gate, 1);
    desat = 1; cyc(40);
    chk("R4 desat trip fault_n", fault_n, 0);
    chk("R4 desat trip gate", gate, 0);
    desat = 0;
    watch(50, hi, lo);
    chk("R4 latched gate stays off", hi, 0);
    chk("R4 latched fault_n", fault_n, 0);
  endtask

  task automatic t_clear;
    en = 0; cyc(20); en = 1; cyc(20);
    chk("R6 short low keeps fault", fault_n, 0);
    chk("R6 gate off while faulted", gate, 0);
    en = 0; cyc(100); en = 1; cyc(20);
    chk("R6 long low clears fault", fault_n, 1);
    chk("R6 gate returns", gate, 1);
  endtask

  task automatic t_uv;
    uv_in = 1; cyc(6);
    chk("R7 uv_in gate off", gate, 0);
    chk("R7 uv_in ready low", ready, 0);
    uv_in = 0; cyc(20);
    chk("R7 uv_in recovery gate", gate, 1);
    uv_out = 1; cyc(4);
    chk("R8 uv_out gate off at once", gate, 0);
    chk("R8 uv_out ready delayed", ready, 1);
    cyc(16);
    chk("R8 uv_out ready low later", ready, 0);
    cmd_pos = 0; cmd_neg = 1; cyc(10); cmd_pos = 1; cmd_neg = 0; cyc(10);
    chk("R7 commands ignored under uv_out", gate, 0);
    uv_out = 0; cyc(20);
    chk("R7 uv_out recovery ready", ready, 1);
    chk("R7 uv_out recovery gate", gate, 1);
  endtask

  task automatic t_wdog;
    alive_run = 0; cyc(300);
    chk("R9 link lost ready", ready, 0);
    chk("R9 link lost gate", gate, 0);
    alive_run = 1; cyc(70);
    chk("R9 link restored ready", ready, 1);
    chk("R9 link restored gate", gate, 1);
  endtask

  initial begin
    cyc(3); rst_n = 1;
    t_reset; t_modes; t_glitch; t_desat; t_clear; t_uv; t_wdog;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule